// File: doc/BRIEF.md
# MII Receive Nibble Framer

This block sits between a line decoder and the MAC-facing receive pins of a physical-layer device. It takes one decoded nibble per receive clock, a frame-present flag and an invalid-symbol flag, and produces the registered receive data bus, data-valid and error outputs for the MAC. All outputs change on the receive clock, which runs at 25 MHz at 100 Mbps and 2.5 MHz at 10 Mbps.

A speed select input picks the framing rule. At 100 Mbps every nibble of the frame, preamble included, goes to the MAC one clock after it arrives. Any nibble flagged as an invalid symbol is replaced by the code 4'b1110 and marked with the error output. At 10 Mbps the preamble is dropped. A one-nibble delay register keeps each nibble until the next one arrives. The block starts data-valid on the value 5 that is immediately followed by the value D, which together form the start-of-frame delimiter. The 10 Mbps path therefore has two clocks of latency.

Top module: `mii_rx_framer`

## Requirements
- R1: While rst_ni is low, rxd_o, rx_dv_o and rx_er_o are all zero.
- R2: With speed_100_i high, each nibble present while frame_i is high appears on rxd_o with rx_dv_o high on the next clock edge, in order, preamble included.
- R3: With speed_100_i high, a nibble whose sym_err_i is high appears as rxd_o = 4'b1110 with rx_er_o high for that one cycle; nibbles without the flag have rx_er_o low.
- R4: With speed_100_i high, rx_dv_o and rx_er_o are low after the first clock edge at which frame_i is low.
- R5: With speed_100_i low, rx_dv_o first rises with rxd_o = 4'h5, which is the first nibble of the first pair of consecutive nibbles 4'h5 then 4'hD in the frame. Every earlier nibble is suppressed, and every nibble from that 4'h5 onward is passed in order, two edges after it arrives.
- R6: With speed_100_i low, a frame that contains no 4'h5 immediately followed by 4'hD never raises rx_dv_o.
- R7: With speed_100_i low, sym_err_i has no effect: rx_er_o stays low and the flagged nibble is passed unchanged.
- R8: With speed_100_i low, the last nibble is still presented on the first edge at which frame_i is low, and rx_dv_o is low after the second such edge.
- R9: rxd_o is zero in every cycle where rx_dv_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| speed_100_i | input | 1 | 1: 100 Mbps framing, 0: 10 Mbps framing; changed only between frames |
| frame_i | input | 1 | High while a frame nibble is present on nib_i; low for at least one cycle between frames |
| nib_i | input | 4 | Decoded receive nibble |
| sym_err_i | input | 1 | Current nibble came from an invalid line symbol |
| rxd_o | output | 4 | Receive data to the MAC |
| rx_dv_o | output | 1 | Receive data valid |
| rx_er_o | output | 1 | Receive error |

## Verification
A wrong state in the delimiter hunt shows at the ports in one of two ways. Data-valid may rise on a preamble nibble. Or the delimiter nibble 4'h5 may be missing from the start of the passed stream. Either shows two edges after the delimiter arrives. A stale or lost delay-register entry shows as a wrong final nibble, or as data-valid staying high one cycle too long or too short after frame_i falls. The scoreboard compares every data-valid nibble in order, so a single skipped, duplicated or corrupted nibble is reported in the cycle it appears. Frames with no delimiter, frames whose delimiter is preceded by a stray D, and frames with a late 5-D pattern in the payload check that only the first pair opens a frame.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  localparam int unsigned NIB_W = 4;

  localparam logic [NIB_W-1:0] PRE_NIB = 4'h5;
  localparam logic [NIB_W-1:0] SFD_NIB = 4'hD;
  localparam logic [NIB_W-1:0] ERR_NIB = 4'hE;

  typedef struct packed {
    logic             vld;
    logic             err;
    logic [NIB_W-1:0] nib;
  } nib_t;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_PASS = 1'b1
  } hunt_st_e;
endpackage

// File: rtl/mii_rx_stage.sv
module mii_rx_stage
  import mii_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  nib_t d_i,
  output nib_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/mii_rx_sfd_hunt.sv
module mii_rx_sfd_hunt
  import mii_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic speed_100_i,
  input  nib_t cur_i,
  input  nib_t held_i,
  output logic emit_o
);
  hunt_st_e st_q, st_d;
  logic     sfd_hit;

  // held nibble is the 5, current nibble is the D
  assign sfd_hit = held_i.vld && (held_i.nib == PRE_NIB) &&
                   cur_i.vld  && (cur_i.nib  == SFD_NIB);

  always_comb begin
    st_d   = st_q;
    emit_o = 1'b0;
    if (speed_100_i) begin
      st_d = ST_HUNT;
    end else begin
      unique case (st_q)
        ST_HUNT: begin
          emit_o = sfd_hit;
          if (sfd_hit) st_d = ST_PASS;
        end
        ST_PASS: begin
          emit_o = held_i.vld;
          if (!held_i.vld) st_d = ST_HUNT;
        end
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_HUNT;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/mii_rx_out_reg.sv
module mii_rx_out_reg
  import mii_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             speed_100_i,
  input  nib_t             cur_i,
  input  nib_t             held_i,
  input  logic             emit_i,
  output logic [NIB_W-1:0] rxd_o,
  output logic             rx_dv_o,
  output logic             rx_er_o
);
  logic [NIB_W-1:0] rxd_d;
  logic             dv_d, er_d;

  always_comb begin
    if (speed_100_i) begin
      dv_d  = cur_i.vld;
      er_d  = cur_i.vld && cur_i.err;
      rxd_d = !cur_i.vld ? '0 : (cur_i.err ? ERR_NIB : cur_i.nib);
    end else begin
      dv_d  = emit_i;
      er_d  = 1'b0;
      rxd_d = emit_i ? held_i.nib : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxd_o   <= '0;
      rx_dv_o <= 1'b0;
      rx_er_o <= 1'b0;
    end else begin
      rxd_o   <= rxd_d;
      rx_dv_o <= dv_d;
      rx_er_o <= er_d;
    end
  end
endmodule

// File: rtl/mii_rx_framer.sv
module mii_rx_framer
  import mii_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             speed_100_i,
  input  logic             frame_i,
  input  logic [NIB_W-1:0] nib_i,
  input  logic             sym_err_i,
  output logic [NIB_W-1:0] rxd_o,
  output logic             rx_dv_o,
  output logic             rx_er_o
);
  nib_t cur, held;
  logic emit;

  assign cur.vld = frame_i;
  assign cur.err = sym_err_i;
  assign cur.nib = nib_i;

  mii_rx_stage u_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cur),
    .q_o    (held)
  );

  mii_rx_sfd_hunt u_hunt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .speed_100_i (speed_100_i),
    .cur_i       (cur),
    .held_i      (held),
    .emit_o      (emit)
  );

  mii_rx_out_reg u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .speed_100_i (speed_100_i),
    .cur_i       (cur),
    .held_i      (held),
    .emit_i      (emit),
    .rxd_o       (rxd_o),
    .rx_dv_o     (rx_dv_o),
    .rx_er_o     (rx_er_o)
  );
endmodule

// File: rtl/mii_rx_framer_chk.sv
module mii_rx_framer_chk
  import mii_rx_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             speed_100_i,
  input logic             frame_i,
  input logic [NIB_W-1:0] nib_i,
  input logic             sym_err_i,
  input logic [NIB_W-1:0] rxd_o,
  input logic             rx_dv_o,
  input logic             rx_er_o
);
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (rxd_o == '0 && !rx_dv_o && !rx_er_o)); // R1

  AST_FAST_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (speed_100_i && frame_i) |=> rx_dv_o); // R2

  AST_ERR_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_er_o |-> (rx_dv_o && rxd_o == ERR_NIB)); // R3

  AST_FAST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (speed_100_i && !frame_i) |=> (!rx_dv_o && !rx_er_o)); // R4

  AST_SLOW_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rx_dv_o) && !$past(speed_100_i)) |-> rxd_o == PRE_NIB); // R5

  AST_SLOW_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(speed_100_i) |-> !rx_er_o); // R7

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_dv_o |-> rxd_o == '0); // R9
endmodule

bind mii_rx_framer mii_rx_framer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .speed_100_i (speed_100_i),
  .frame_i     (frame_i),
  .nib_i       (nib_i),
  .sym_err_i   (sym_err_i),
  .rxd_o       (rxd_o),
  .rx_dv_o     (rx_dv_o),
  .rx_er_o     (rx_er_o)
);

// File: tb/mii_rx_framer_test.sv
`timescale 1ns/1ps
module mii_rx_framer_test;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       speed_100_i;
  logic       frame_i;
  logic [3:0] nib_i;
  logic       sym_err_i;
  logic [3:0] rxd_o;
  logic       rx_dv_o;
  logic       rx_er_o;

  always #2 clk_i = ~clk_i;

  mii_rx_framer uut (.*);

  typedef struct {
    logic [3:0] nib;
    logic       er;
    string      req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  int   dv_cnt = 0;
  bit   mon_en = 1'b0;
  bit   done   = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compare every valid output nibble against the queue
  always @(negedge clk_i) begin
    if (mon_en) begin
      if (rx_dv_o) begin
        dv_cnt++;
        if (q.size() == 0) begin
          chk(1'b0, "R6", "unexpected valid nibble", int'(rxd_o), 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(rxd_o == e.nib, e.req, "rxd", int'(rxd_o), int'(e.nib));
          chk(rx_er_o == e.er, e.req, "rx_er", int'(rx_er_o), int'(e.er));
        end
      end else begin
        chk(rxd_o == 4'h0 && !rx_er_o, "R9", "idle outputs",
            int'({rx_er_o, rxd_o}), 0);
      end
    end
  end

  task automatic send(input bit spd, input logic [3:0] n[$], input bit e[$],
                      input string req);
    int start;
    @(negedge clk_i);
    speed_100_i = spd;
    repeat (2) @(negedge clk_i);
    start = -1;
    if (spd) begin
      start = 0;
      foreach (n[i]) q.push_back('{e[i] ? 4'hE : n[i], e[i], req});
    end else begin
      for (int i = 0; i + 1 < n.size(); i++) begin
        if (n[i] == 4'h5 && n[i+1] == 4'hD) begin
          start = i;
          break;
        end
      end
      if (start >= 0)
        for (int i = start; i < n.size(); i++) q.push_back('{n[i], 1'b0, req});
    end
    dv_cnt = 0;
    foreach (n[i]) begin
      frame_i   = 1'b1;
      nib_i     = n[i];
      sym_err_i = e[i];
      @(negedge clk_i);
    end
    frame_i   = 1'b0;
    nib_i     = 4'h0;
    sym_err_i = 1'b0;
    @(negedge clk_i);
    if (spd) chk(!rx_dv_o && !rx_er_o, "R4", "dv/er after end",
                 int'({rx_dv_o, rx_er_o}), 0);
    else if (start >= 0) chk(rx_dv_o, "R8", "last nibble still valid",
                             int'(rx_dv_o), 1);
    @(negedge clk_i);
    if (!spd) chk(!rx_dv_o, "R8", "dv low on second edge", int'(rx_dv_o), 0);
    repeat (2) @(negedge clk_i);
    chk(q.size() == 0, req, "items left in scoreboard", q.size(), 0);
    if (start < 0) chk(dv_cnt == 0, "R6", "dv cycles without delimiter", dv_cnt, 0);
    q.delete();
  endtask

  initial begin
    rst_ni      = 1'b0;
    speed_100_i = 1'b1;
    frame_i     = 1'b0;
    nib_i       = 4'h0;
    sym_err_i   = 1'b0;
    repeat (2) @(negedge clk_i);
    // R1: outputs quiet while reset held, even with a frame driven
    frame_i = 1'b1;
    nib_i   = 4'h7;
    @(negedge clk_i);
    chk(rxd_o == 4'h0 && !rx_dv_o && !rx_er_o, "R1", "reset outputs",
        int'({rx_dv_o, rx_er_o, rxd_o}), 0);
    frame_i = 1'b0;
    nib_i   = 4'h0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    mon_en = 1'b1;

    // R2: full pass-through with preamble at 100 Mbps
    send(1'b1, '{4'h5, 4'h5, 4'h5, 4'h5, 4'h5, 4'h5, 4'h5, 4'hD, 4'h1, 4'hA, 4'h3, 4'hF},
         '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, "R2");
    // R3: invalid symbols replaced at 100 Mbps, incl. first and last nibble
    send(1'b1, '{4'h5, 4'h5, 4'hD, 4'h2, 4'h7, 4'h9},
         '{1, 0, 0, 1, 0, 1}, "R3");
    // R5: preamble stripped at 10 Mbps
    send(1'b0, '{4'h5, 4'h5, 4'h5, 4'h5, 4'h5, 4'hD, 4'h4, 4'hB, 4'h0, 4'h6},
         '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, "R5");
    // R5: stray D before the real delimiter, late 5-D in payload
    send(1'b0, '{4'h5, 4'hD, 4'hD, 4'h8}, '{0, 0, 0, 0}, "R5");
    send(1'b0, '{4'h5, 4'h3, 4'hD, 4'h5, 4'h5, 4'hD, 4'hC, 4'h5, 4'hD, 4'h1},
         '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0}, "R5");
    // R8: minimal frame, delimiter only
    send(1'b0, '{4'h5, 4'hD}, '{0, 0}, "R8");
    // R6: no delimiter, frame ends on a 5
    send(1'b0, '{4'h5, 4'h5, 4'h5, 4'h5, 4'hA, 4'h5}, '{0, 0, 0, 0, 0, 0}, "R6");
    send(1'b0, '{4'hD, 4'h5}, '{0, 0}, "R6");
    // R7: error flag ignored at 10 Mbps
    send(1'b0, '{4'h5, 4'h5, 4'hD, 4'h9, 4'h2, 4'h3}, '{1, 0, 1, 1, 0, 1}, "R7");
    // back to 100 Mbps, right after a 10 Mbps frame
    send(1'b1, '{4'h5, 4'hD, 4'hE, 4'h0}, '{0, 0, 0, 0}, "R2");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule